// File: doc/BRIEF.md
# TLP Header-and-Data Qword Packer

This block turns a single-dword PCI Express request into a stream of 64-bit beats for a transmit register pair. Each beat has a low 32-bit half and a high 32-bit half. The request arrives as four header dwords, a format bit and one data dword. The format bit says whether three or four of the header dwords are used. A further address bit says whether the target address sits in the upper dword of a qword.

The first beat always carries the first two header dwords. Where the data dword lands depends on the header length and on the alignment bit. It goes either into the unused upper half after a three-dword header, or into a third beat. In the third beat it takes the low or the high lane, according to the alignment. Every slot that holds neither header nor data is written with zeros, and both write strobes are raised on every beat. A last flag marks the final beat.

The upstream side uses a valid/ready handshake. The downstream side holds each beat until it is taken.

Top module: `tlp_qword_packer`

## Requirements
- R1: The first beat of every packet carries header dword 0 (`req_hdr[31:0]`) in `beat_lo` and header dword 1 (`req_hdr[63:32]`) in `beat_hi`.
- R2: With `req_fmt4`=0 (3-dword header) and `req_qw_odd`=1, the second beat carries header dword 2 in `beat_lo` and the data dword in `beat_hi`, and the packet ends on that beat.
- R3: With `req_fmt4`=0 and `req_qw_odd`=0, the second beat has header dword 2 in `beat_lo` and zero in `beat_hi`. A third beat follows with the data in `beat_lo` and zero in `beat_hi`.
- R4: With `req_fmt4`=1 (4-dword header), the second beat carries header dword 2 in `beat_lo` and header dword 3 (`req_hdr[127:96]`) in `beat_hi`, and the packet always has three beats.
- R5: In a 4-dword packet, the third beat puts the data in `beat_lo` with `beat_hi` zero when `req_qw_odd`=0. When `req_qw_odd`=1 it puts the data in `beat_hi` with `beat_lo` zero.
- R6: `req_qw_odd`=1 means the address is not qword-aligned (byte address bit 2 set) and `req_fmt4`=1 selects the 4-dword header. Header dword 3 has no effect when `req_fmt4`=0.
- R7: Both `beat_lo_we` and `beat_hi_we` are 1 on every valid beat. While `beat_valid` is 0, `beat_lo`, `beat_hi`, both strobes and `beat_last` are all 0.
- R8: `beat_last` is 1 on the final beat of a packet only: beat 2 in the case of R2, and beat 3 otherwise.
- R9: While `beat_valid`=1 and `beat_ready`=0, the beat outputs stay unchanged on the next cycle.
- R10: `req_ready` is 1 exactly when no beat is pending. The first beat is valid in the cycle after a request is accepted. Each later beat is valid in the cycle after the previous beat is taken. `req_ready` returns in the cycle after the last beat is taken.
- R11: During and right after synchronous reset (`rst`=1), `beat_valid` is 0, all beat outputs are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Packer is idle and takes the request |
| req_fmt4 | input | 1 | 1: 4-dword header, 0: 3-dword header |
| req_qw_odd | input | 1 | Byte address bit 2; 1 means not qword-aligned |
| req_hdr | input | 128 | Header dwords, dword k at bits [32k+31:32k] |
| req_data | input | 32 | The single data dword |
| beat_ready | input | 1 | Downstream takes the current beat |
| beat_valid | output | 1 | A beat is presented |
| beat_lo | output | 32 | Value for the low register |
| beat_hi | output | 32 | Value for the high register |
| beat_lo_we | output | 1 | Write strobe for the low register |
| beat_hi_we | output | 1 | Write strobe for the high register |
| beat_last | output | 1 | Final beat of the packet |

## Verification
The outputs are registered. The first beat is due one cycle after the edge that accepts a request. Each following beat is due one cycle after the edge where the previous beat is taken. `req_ready` rises one cycle after the last beat is taken. The bench drives inputs just after the rising edge and compares at the falling edge. At that point it checks the outputs against a queue of expected beats, built by a separate slot-filling model. Only then does it apply the handshakes it saw to its model, the same handshakes the design acts on at the next rising edge. Random stalls of `beat_ready` test the hold rule. Requests kept valid while the packer is busy test that those requests are ignored.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;

  // Position of a beat inside one packet.
  typedef enum logic [1:0] {
    BEAT_HDR01 = 2'd0,
    BEAT_HDR23 = 2'd1,
    BEAT_TAIL  = 2'd2
  } beat_idx_e;

  // Number of header dwords the request port carries.
  localparam int unsigned HDR_SLOTS = 4;

endpackage

// File: rtl/tlp_req_capture.sv
module tlp_req_capture #(
  parameter int unsigned DW = 32
) (
  input  logic                                     clk,
  input  logic                                     load,
  input  logic                                     fmt4_in,
  input  logic                                     odd_in,
  input  logic [tlp_pack_pkg::HDR_SLOTS*DW-1:0]    hdr_in,
  input  logic [DW-1:0]                            data_in,
  output logic                                     fmt4_q,
  output logic                                     odd_q,
  output logic [tlp_pack_pkg::HDR_SLOTS*DW-1:0]    hdr_q,
  output logic [DW-1:0]                            data_q
);
  localparam int unsigned NSLOT = tlp_pack_pkg::HDR_SLOTS;

  // One register per header dword, written only when a request is taken.
  for (genvar k = 0; k < NSLOT; k++) begin : g_hdr
    always_ff @(posedge clk) begin
      if (load) hdr_q[k*DW +: DW] <= hdr_in[k*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      fmt4_q <= fmt4_in;
      odd_q  <= odd_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/tlp_beat_compose.sv
module tlp_beat_compose #(
  parameter int unsigned DW = 32
) (
  input  tlp_pack_pkg::beat_idx_e                  idx,
  input  logic                                     fmt4,
  input  logic                                     odd,
  input  logic [tlp_pack_pkg::HDR_SLOTS*DW-1:0]    hdr,
  input  logic [DW-1:0]                            data,
  output logic [DW-1:0]                            lo,
  output logic [DW-1:0]                            hi,
  output logic                                     last
);
  import tlp_pack_pkg::*;
  localparam int unsigned NSLOT = HDR_SLOTS;
  localparam logic [DW-1:0] FILL = '0;

  logic [DW-1:0] hw [NSLOT];
  for (genvar k = 0; k < NSLOT; k++) begin : g_split
    assign hw[k] = hdr[k*DW +: DW];
  end

  always_comb begin
    lo   = FILL;
    hi   = FILL;
    last = 1'b0;
    case (idx)
      BEAT_HDR01: begin
        lo = hw[0];
        hi = hw[1];
      end
      BEAT_HDR23: begin
        lo   = hw[2];
        hi   = fmt4 ? hw[3] : (odd ? data : FILL);
        last = !fmt4 && odd;
      end
      BEAT_TAIL: begin
        // The short-header odd case never reaches this beat.
        lo   = odd ? FILL : data;
        hi   = odd ? data : FILL;
        last = 1'b1;
      end
      default: begin
        lo   = FILL;
        hi   = FILL;
        last = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tlp_beat_sequencer.sv
module tlp_beat_sequencer #(
  parameter int unsigned DW = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [DW-1:0]            lo_in,
  input  logic [DW-1:0]            hi_in,
  input  logic                     last_in,
  input  logic                     beat_ready,
  output tlp_pack_pkg::beat_idx_e  next_idx,
  output logic                     beat_valid,
  output logic [DW-1:0]            beat_lo,
  output logic [DW-1:0]            beat_hi,
  output logic                     beat_lo_we,
  output logic                     beat_hi_we,
  output logic                     beat_last
);
  import tlp_pack_pkg::*;

  beat_idx_e idx_q;
  logic      fire;
  logic      advance;
  logic      load;

  assign fire     = beat_valid && beat_ready;
  assign advance  = fire && !beat_last;
  assign load     = start || advance;
  assign next_idx = start ? BEAT_HDR01 : beat_idx_e'(idx_q + 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_valid <= 1'b0;
      beat_lo    <= '0;
      beat_hi    <= '0;
      beat_lo_we <= 1'b0;
      beat_hi_we <= 1'b0;
      beat_last  <= 1'b0;
      idx_q      <= BEAT_HDR01;
    end else if (load) begin
      beat_valid <= 1'b1;
      beat_lo    <= lo_in;
      beat_hi    <= hi_in;
      beat_lo_we <= 1'b1;
      beat_hi_we <= 1'b1;
      beat_last  <= last_in;
      idx_q      <= next_idx;
    end else if (fire) begin
      beat_valid <= 1'b0;
      beat_lo    <= '0;
      beat_hi    <= '0;
      beat_lo_we <= 1'b0;
      beat_hi_we <= 1'b0;
      beat_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/tlp_qword_packer.sv
module tlp_qword_packer #(
  parameter int unsigned DW = 32
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_fmt4,
  input  logic                                   req_qw_odd,
  input  logic [tlp_pack_pkg::HDR_SLOTS*DW-1:0]  req_hdr,
  input  logic [DW-1:0]                          req_data,
  input  logic                                   beat_ready,
  output logic                                   beat_valid,
  output logic [DW-1:0]                          beat_lo,
  output logic [DW-1:0]                          beat_hi,
  output logic                                   beat_lo_we,
  output logic                                   beat_hi_we,
  output logic                                   beat_last
);
  import tlp_pack_pkg::*;
  localparam int unsigned HW = HDR_SLOTS * DW;

  logic            accept;
  logic            fmt4_q, odd_q;
  logic [HW-1:0]   hdr_q;
  logic [DW-1:0]   data_q;
  logic            fmt4_s, odd_s;
  logic [HW-1:0]   hdr_s;
  logic [DW-1:0]   data_s;
  logic [DW-1:0]   lo_n, hi_n;
  logic            last_n;
  beat_idx_e       idx_n;

  assign req_ready = !beat_valid;
  assign accept    = req_valid && req_ready;

  tlp_req_capture #(.DW(DW)) u_cap (
    .clk     (clk),
    .load    (accept),
    .fmt4_in (req_fmt4),
    .odd_in  (req_qw_odd),
    .hdr_in  (req_hdr),
    .data_in (req_data),
    .fmt4_q  (fmt4_q),
    .odd_q   (odd_q),
    .hdr_q   (hdr_q),
    .data_q  (data_q)
  );

  // The first beat is built straight from the port; later beats from the copy.
  assign fmt4_s = accept ? req_fmt4   : fmt4_q;
  assign odd_s  = accept ? req_qw_odd : odd_q;
  assign hdr_s  = accept ? req_hdr    : hdr_q;
  assign data_s = accept ? req_data   : data_q;

  tlp_beat_compose #(.DW(DW)) u_comp (
    .idx  (idx_n),
    .fmt4 (fmt4_s),
    .odd  (odd_s),
    .hdr  (hdr_s),
    .data (data_s),
    .lo   (lo_n),
    .hi   (hi_n),
    .last (last_n)
  );

  tlp_beat_sequencer #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .lo_in      (lo_n),
    .hi_in      (hi_n),
    .last_in    (last_n),
    .beat_ready (beat_ready),
    .next_idx   (idx_n),
    .beat_valid (beat_valid),
    .beat_lo    (beat_lo),
    .beat_hi    (beat_hi),
    .beat_lo_we (beat_lo_we),
    .beat_hi_we (beat_hi_we),
    .beat_last  (beat_last)
  );
endmodule

// File: rtl/tlp_qword_packer_chk.sv
module tlp_qword_packer_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          beat_ready,
  input logic          beat_valid,
  input logic [DW-1:0] beat_lo,
  input logic [DW-1:0] beat_hi,
  input logic          beat_lo_we,
  input logic          beat_hi_we,
  input logic          beat_last
);
  p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_lo) && $stable(beat_hi) && $stable(beat_last));

  p_both_strobes_r7: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> beat_lo_we && beat_hi_we);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |-> beat_lo == '0 && beat_hi == '0 && !beat_lo_we && !beat_hi_we && !beat_last);

  p_accept_starts_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> beat_valid && !beat_last);

  p_busy_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> !req_ready);

  p_last_ends_r8: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && beat_last |=> !beat_valid && req_ready);

  p_mid_continues_r8: assert property (@(posedge clk) disable iff (rst)
    beat_valid && beat_ready && !beat_last |=> beat_valid);
endmodule

bind tlp_qword_packer tlp_qword_packer_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .beat_ready (beat_ready),
  .beat_valid (beat_valid),
  .beat_lo    (beat_lo),
  .beat_hi    (beat_hi),
  .beat_lo_we (beat_lo_we),
  .beat_hi_we (beat_hi_we),
  .beat_last  (beat_last)
);

// File: tb/tb_tlp_qword_packer.sv
module tb_tlp_qword_packer;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_fmt4 = 1'b0;
  logic          req_qw_odd = 1'b0;
  logic [4*DW-1:0] req_hdr = '0;
  logic [DW-1:0] req_data = '0;
  logic          beat_ready = 1'b1;
  logic          beat_valid;
  logic [DW-1:0] beat_lo, beat_hi;
  logic          beat_lo_we, beat_hi_we, beat_last;

  always #2 clk = ~clk;

  tlp_qword_packer #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_fmt4(req_fmt4), .req_qw_odd(req_qw_odd), .req_hdr(req_hdr),
    .req_data(req_data), .beat_ready(beat_ready), .beat_valid(beat_valid),
    .beat_lo(beat_lo), .beat_hi(beat_hi), .beat_lo_we(beat_lo_we),
    .beat_hi_we(beat_hi_we), .beat_last(beat_last)
  );

  int n_chk = 0;
  int n_fail = 0;
  int stall_pct = 0;
  logic [2*DW:0] exp_q [$];
  string         tag_q [$];
  bit            prev_stall = 0;
  logic [2*DW:0] prev_beat = '0;
  bit            done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [2*DW:0] act, input logic [2*DW:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Slot-filling model: header dwords first, then pad until the data lane matches.
  task automatic model_push(input bit fmt4, input bit odd,
                            input logic [4*DW-1:0] hdr, input logic [DW-1:0] data);
    logic [DW-1:0] slots [$];
    int nb;
    for (int k = 0; k < (fmt4 ? 4 : 3); k++) slots.push_back(hdr[k*DW +: DW]);
    while ((slots.size() % 2) != (odd ? 1 : 0)) slots.push_back('0);
    slots.push_back(data);
    if (slots.size() % 2 != 0) slots.push_back('0);
    nb = slots.size() / 2;
    for (int b = 0; b < nb; b++) begin
      string t;
      exp_q.push_back({(b == nb - 1), slots[2*b+1], slots[2*b]});
      if (b == 0)      t = "R1";
      else if (b == 1) t = fmt4 ? "R4" : (odd ? "R2 R6" : "R3 R6");
      else             t = fmt4 ? "R5 R6" : "R3 R6";
      tag_q.push_back(t);
    end
  endtask

  // Compare at the falling edge, then advance the model by the handshakes seen.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (exp_q.size() == 0) begin
        check(!beat_valid && req_ready, "R10", "idle valid/ready",
              {63'd0, beat_valid, req_ready}, {63'd0, 1'b0, 1'b1});
        check({beat_last, beat_hi, beat_lo} == '0 && !beat_lo_we && !beat_hi_we,
              "R7", "idle outputs", {beat_last, beat_hi, beat_lo}, '0);
      end else begin
        check(beat_valid && !req_ready, "R10", "busy valid/ready",
              {63'd0, beat_valid, req_ready}, {63'd0, 1'b1, 1'b0});
        check({beat_hi, beat_lo} == exp_q[0][2*DW-1:0], tag_q[0], "beat content",
              {1'b0, beat_hi, beat_lo}, {1'b0, exp_q[0][2*DW-1:0]});
        check(beat_last == exp_q[0][2*DW], "R8", "last flag",
              {64'd0, beat_last}, {64'd0, exp_q[0][2*DW]});
        check(beat_lo_we && beat_hi_we, "R7", "strobes",
              {63'd0, beat_lo_we, beat_hi_we}, {63'd0, 2'b11});
      end
      if (prev_stall)
        check({beat_last, beat_hi, beat_lo} == prev_beat, "R9", "hold under stall",
              {beat_last, beat_hi, beat_lo}, prev_beat);
      prev_stall = beat_valid && !beat_ready;
      prev_beat  = {beat_last, beat_hi, beat_lo};
      if (beat_valid && beat_ready && exp_q.size() > 0) begin
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      if (req_valid && req_ready) model_push(req_fmt4, req_qw_odd, req_hdr, req_data);
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      beat_ready = ($urandom % 100) >= stall_pct;
    end
  end

  task automatic send(input bit fmt4, input bit odd);
    req_valid  = 1'b1;
    req_fmt4   = fmt4;
    req_qw_odd = odd;
    req_hdr    = {$urandom, $urandom, $urandom, $urandom};
    req_data   = $urandom;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    // Keep valid high with new values on some requests; busy must ignore them (R10).
    if (($urandom % 2) == 0) begin
      req_hdr  = {$urandom, $urandom, $urandom, $urandom};
      req_data = $urandom;
    end else begin
      req_valid = 1'b0;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!beat_valid && req_ready && {beat_hi, beat_lo} == '0 && !beat_last,
          "R11", "reset state", {beat_last, beat_hi, beat_lo}, '0);
    @(posedge clk); #1;
    rst = 1'b0;
    for (int ph = 0; ph < 3; ph++) begin
      stall_pct = (ph == 0) ? 0 : (ph == 1 ? 40 : 75);
      for (int n = 0; n < 12; n++) begin
        for (int c = 0; c < 4; c++) send(c[1], c[0]);
      end
    end
    req_valid = 1'b0;
    stall_pct = 0;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R10", "all beats delivered",
          {33'd0, exp_q.size()}, '0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=complete");
    finish_run();
  end
endmodule